// File: doc/BRIEF.md
# Three-Phase Hall Commutation Decoder

This block turns the rotor position reported by three Hall-effect sensors into the six switch enables of a three-phase brushless DC motor bridge. Each clock it resolves the synchronized sensor code into one of six electrical steps. The mapping depends on the sensor spacing and on the rotation direction. The block then enables one upper and one lower switch on two different legs of the bridge. Sensor codes that cannot occur at the chosen spacing blank the bridge and raise a flag.

A mode input switches to four-phase operation. In that mode two sensors select one of four single switches. A brake input shorts the windings through the three lower switches and overrides every other input. A drive-allow input comes from upstream gating (enable, PWM comparison, overcurrent latch) and turns all switches off unless brake is active. A parameter selects complementary upper-gate polarity for P-channel drivers.

Top module: `bldc_commutator`

## Requirements
- R1: With fwd_i=1, quad_mode_i=0, brake_i=0 and drive_ok_i=1, the code {S1,S2,S3}={hall_i[2],hall_i[1],hall_i[0]} selects step 0..5 by its position in the spacing's ordered list. The lists are: spacing_i=0: 000,100,110,111,011,001. spacing_i=1: 001,101,100,110,010,011. spacing_i=2: 010,110,100,101,001,011. spacing_i=3: 011,111,110,100,000,001. Steps 0..5 enable the pairs (O1,O5),(O3,O5),(O3,O4),(O2,O4),(O2,O6),(O1,O6), where On is sw_o[n-1] and exactly those two bits are active.
- R2: With fwd_i=0 and the other conditions of R1, step k enables the pair that R1 gives for step (k+3) mod 6.
- R3: A code missing from the selected list (with quad_mode_i=0 and brake_i=0) drives all six switches inactive and sets bad_code_o.
- R4: With quad_mode_i=1 and spacing_i=0, hall_i[0] is ignored. For fwd_i=1 the S1,S2 codes 00,10,11,01 enable only O1,O3,O4,O6 respectively. For fwd_i=0 the same codes enable O4,O6,O1,O3. bad_code_o stays 0.
- R5: With quad_mode_i=1 and spacing_i not 0, every code counts as invalid: the switches are blanked and bad_code_o is set.
- R6: brake_i=1 makes O1..O3 inactive and O4..O6 active, whatever the other inputs are, and holds bad_code_o at 0.
- R7: drive_ok_i=0 with brake_i=0 makes all switches inactive. bad_code_o still reports the validity of the code.
- R8: With INVERT_UPPER=1, sw_o[2:0] is the bitwise inverse of the standard value (active upper switch = 0). sw_o[5:3] is unchanged.
- R9: While rst_n is low, all switches are inactive and bad_code_o is 0.
- R10: A change on hall_i shows on the outputs after the third rising clock edge. A change on any other input shows after the first.
- R11: The upper and lower switches of one leg (O1/O4, O2/O5, O3/O6) are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Sensor code, bit 2 = S1, bit 1 = S2, bit 0 = S3 |
| spacing_i | input | 2 | Sensor spacing: 0=60, 1=120, 2=240, 3=300 degrees |
| quad_mode_i | input | 1 | Four-phase mode |
| fwd_i | input | 1 | Direction, 1 = forward |
| brake_i | input | 1 | Brake, highest priority |
| drive_ok_i | input | 1 | Drive allow from upstream gating |
| sw_o | output | 6 | Switch enables, bit n-1 = On |
| bad_code_o | output | 1 | Invalid sensor code flag |

## Verification
The bench sweeps every combination of code, spacing, direction, mode, brake and drive-allow against two instances, one with each upper polarity. This exposes a wrong or rotated sequence table: one valid code would light the wrong pair. A reverse offset other than three steps would show the same way. If the four-phase spacing rule were missing, power would flow at an illegal setting. If brake lost its priority, the windings would be released while drive-allow is low or the code is bad. A separate test counts edges after a sensor change. It catches a synchronizer one flop short or one flop long, which would move the output a cycle early or late.

// File: rtl/bldc_comm_pkg.sv
package bldc_comm_pkg;

   localparam int unsigned HALL_W  = 3;
   localparam int unsigned LEG_N   = 3;
   localparam int unsigned STEP_N  = 6;
   localparam int unsigned QUAD_N  = 4;
   localparam int unsigned STEP_W  = $clog2(STEP_N);

   typedef logic [HALL_W-1:0] hall_t;
   typedef logic [STEP_W-1:0] step_t;

   typedef enum logic [1:0] {
      SP_60  = 2'd0,
      SP_120 = 2'd1,
      SP_240 = 2'd2,
      SP_300 = 2'd3
   } spacing_e;

   typedef struct packed {
      logic  valid;
      step_t step;
   } rotor_pos_t;

   typedef struct packed {
      logic [LEG_N-1:0] low;
      logic [LEG_N-1:0] high;
   } bridge_t;

   // Ordered code list per spacing; index = electrical step.
   function automatic hall_t step_code(spacing_e sp, step_t idx);
      hall_t c;
      c = '0;
      unique case (sp)
         SP_60: case (idx)
            3'd0: c = 3'b000;  3'd1: c = 3'b100;  3'd2: c = 3'b110;
            3'd3: c = 3'b111;  3'd4: c = 3'b011;  default: c = 3'b001;
         endcase
         SP_120: case (idx)
            3'd0: c = 3'b001;  3'd1: c = 3'b101;  3'd2: c = 3'b100;
            3'd3: c = 3'b110;  3'd4: c = 3'b010;  default: c = 3'b011;
         endcase
         SP_240: case (idx)
            3'd0: c = 3'b010;  3'd1: c = 3'b110;  3'd2: c = 3'b100;
            3'd3: c = 3'b101;  3'd4: c = 3'b001;  default: c = 3'b011;
         endcase
         default: case (idx)
            3'd0: c = 3'b011;  3'd1: c = 3'b111;  3'd2: c = 3'b110;
            3'd3: c = 3'b100;  3'd4: c = 3'b000;  default: c = 3'b001;
         endcase
      endcase
      return c;
   endfunction

   function automatic step_t step_advance(step_t s, int unsigned by, int unsigned modulo);
      int unsigned t;
      t = (int'(s) + by) % modulo;
      return step_t'(t);
   endfunction

endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] chain [STAGES];

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= '0;
               else        chain[g] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= '0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/rotor_locator.sv
module rotor_locator
   import bldc_comm_pkg::*;
(
   input  hall_t      hall_i,
   input  spacing_e   spacing_i,
   input  logic       quad_i,
   output rotor_pos_t pos_o
);

   rotor_pos_t six_pos;
   rotor_pos_t four_pos;

   // Six-step search over the selected ordered list.
   always_comb begin
      six_pos = '0;
      for (int i = 0; i < STEP_N; i++) begin
         if (step_code(spacing_i, step_t'(i)) == hall_i) begin
            six_pos.valid = 1'b1;
            six_pos.step  = step_t'(i);
         end
      end
   end

   // Four-phase: S1 = hall[2], S2 = hall[1]; S3 ignored.
   // Gray order 00,10,11,01 -> 0,1,2,3.
   always_comb begin
      four_pos       = '0;
      four_pos.valid = (spacing_i == SP_60);
      four_pos.step  = {1'b0, hall_i[1], hall_i[2] ^ hall_i[1]};
   end

   assign pos_o = quad_i ? four_pos : six_pos;

endmodule

// File: rtl/bridge_encoder.sv
module bridge_encoder
   import bldc_comm_pkg::*;
(
   input  rotor_pos_t pos_i,
   input  logic       fwd_i,
   input  logic       quad_i,
   input  logic       brake_i,
   input  logic       drive_ok_i,
   output bridge_t    drive_o,
   output logic       bad_o
);

   localparam int unsigned REV_SIX  = STEP_N / 2;
   localparam int unsigned REV_QUAD = QUAD_N / 2;

   step_t   eff_step;
   bridge_t six_drive;
   bridge_t four_drive;
   bridge_t run_drive;

   always_comb begin
      if (quad_i)
         eff_step = fwd_i ? pos_i.step : step_advance(pos_i.step, REV_QUAD, QUAD_N);
      else
         eff_step = fwd_i ? pos_i.step : step_advance(pos_i.step, REV_SIX, STEP_N);
   end

   // Upper leg n = O(n+1); lower leg n = O(n+4).
   always_comb begin
      six_drive         = '0;
      six_drive.high[0] = (eff_step == 3'd0) || (eff_step == 3'd5);
      six_drive.high[1] = (eff_step == 3'd3) || (eff_step == 3'd4);
      six_drive.high[2] = (eff_step == 3'd1) || (eff_step == 3'd2);
      six_drive.low[0]  = (eff_step == 3'd2) || (eff_step == 3'd3);
      six_drive.low[1]  = (eff_step == 3'd0) || (eff_step == 3'd1);
      six_drive.low[2]  = (eff_step == 3'd4) || (eff_step == 3'd5);
   end

   always_comb begin
      four_drive = '0;
      unique case (eff_step[1:0])
         2'd0:    four_drive.high[0] = 1'b1;
         2'd1:    four_drive.high[2] = 1'b1;
         2'd2:    four_drive.low[0]  = 1'b1;
         default: four_drive.low[2]  = 1'b1;
      endcase
   end

   assign run_drive = quad_i ? four_drive : six_drive;

   always_comb begin
      if (brake_i) begin
         drive_o = '{low: '1, high: '0};
         bad_o   = 1'b0;
      end else begin
         drive_o = (pos_i.valid && drive_ok_i) ? run_drive : '0;
         bad_o   = !pos_i.valid;
      end
   end

endmodule

// File: rtl/drive_stage.sv
module drive_stage
   import bldc_comm_pkg::*;
#(
   parameter bit INVERT_UPPER = 1'b0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  bridge_t drive_i,
   input  logic    bad_i,
   output logic [2*LEG_N-1:0] sw_o,
   output logic    bad_o
);

   localparam logic [LEG_N-1:0] HIGH_POL = {LEG_N{INVERT_UPPER}};

   bridge_t drive_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= '0;
         bad_o   <= 1'b0;
      end else begin
         drive_q <= drive_i;
         bad_o   <= bad_i;
      end
   end

   generate
      if (INVERT_UPPER) begin : g_inv_high
         assign sw_o = {drive_q.low, drive_q.high ^ HIGH_POL};
      end else begin : g_plain_high
         assign sw_o = {drive_q.low, drive_q.high};
      end
   endgenerate

endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
   import bldc_comm_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          INVERT_UPPER = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] hall_i,
   input  logic [1:0] spacing_i,
   input  logic       quad_mode_i,
   input  logic       fwd_i,
   input  logic       brake_i,
   input  logic       drive_ok_i,
   output logic [5:0] sw_o,
   output logic       bad_code_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   hall_t      hall_s;
   rotor_pos_t pos;
   bridge_t    drive;
   logic       bad;

   hall_sync #(.WIDTH(HALL_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (hall_i),
      .q_o   (hall_s)
   );

   rotor_locator loc_i (
      .hall_i    (hall_s),
      .spacing_i (spacing_e'(spacing_i)),
      .quad_i    (quad_mode_i),
      .pos_o     (pos)
   );

   bridge_encoder enc_i (
      .pos_i      (pos),
      .fwd_i      (fwd_i),
      .quad_i     (quad_mode_i),
      .brake_i    (brake_i),
      .drive_ok_i (drive_ok_i),
      .drive_o    (drive),
      .bad_o      (bad)
   );

   drive_stage #(.INVERT_UPPER(INVERT_UPPER)) out_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .drive_i (drive),
      .bad_i   (bad),
      .sw_o    (sw_o),
      .bad_o   (bad_code_o)
   );

endmodule

// File: rtl/bldc_commutator_chk.sv
module bldc_commutator_chk #(
   parameter bit INVERT_UPPER = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       brake_i,
   input logic       drive_ok_i,
   input logic [5:0] sw_o,
   input logic       bad_code_o
);

   logic       primed;
   logic [2:0] act_hi;
   logic [2:0] act_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   assign act_hi = sw_o[2:0] ^ {3{INVERT_UPPER}};
   assign act_lo = sw_o[5:3];

   a_r6_brake_shorts: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      $past(brake_i) |-> (act_lo == 3'b111 && act_hi == 3'b000 && !bad_code_o));

   a_r7_allow_blanks: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      (!$past(drive_ok_i) && !$past(brake_i)) |-> (act_lo == 3'b000 && act_hi == 3'b000));

   a_r3_flag_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      bad_code_o |-> (act_lo == 3'b000 && act_hi == 3'b000));

   a_r11_no_leg_short: assert property (@(posedge clk) disable iff (!rst_n)
      (act_hi & act_lo) == 3'b000);

   a_r1_one_pair: assert property (@(posedge clk) disable iff (!rst_n || !primed)
      !$past(brake_i) |-> ($countones(act_hi) <= 1 && $countones(act_lo) <= 1));

endmodule

bind bldc_commutator bldc_commutator_chk #(.INVERT_UPPER(INVERT_UPPER)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .brake_i    (brake_i),
   .drive_ok_i (drive_ok_i),
   .sw_o       (sw_o),
   .bad_code_o (bad_code_o)
);

// File: tb/bldc_commutator_tb_top.sv
`timescale 1ns/1ps
module bldc_commutator_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] hall = 3'b000;
   logic [1:0] spacing = 2'd0;
   logic       quad = 1'b0;
   logic       fwd = 1'b1;
   logic       brake = 1'b0;
   logic       drive_ok = 1'b1;
   logic [5:0] sw, sw_inv;
   logic       bad, bad_inv;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   bldc_commutator #(.INVERT_UPPER(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .hall_i(hall), .spacing_i(spacing),
      .quad_mode_i(quad), .fwd_i(fwd), .brake_i(brake), .drive_ok_i(drive_ok),
      .sw_o(sw), .bad_code_o(bad));

   bldc_commutator #(.INVERT_UPPER(1'b1)) dut_inv_i (
      .clk(clk), .rst_n(rst_n), .hall_i(hall), .spacing_i(spacing),
      .quad_mode_i(quad), .fwd_i(fwd), .brake_i(brake), .drive_ok_i(drive_ok),
      .sw_o(sw_inv), .bad_code_o(bad_inv));

   int seq [4][6] = '{'{0,4,6,7,3,1}, '{1,5,4,6,2,3}, '{2,6,4,5,1,3}, '{3,7,6,4,0,1}};
   int up_of [6]  = '{0,2,2,1,1,0};
   int lo_of [6]  = '{4,4,3,3,5,5};
   int quad_code [4] = '{0,2,3,1};
   int quad_out  [4] = '{0,2,3,5};

   // Returns {bad, sw[5:0]} for standard upper polarity.
   function automatic logic [6:0] model(int h, int sp, bit q, bit f, bit bk, bit ok);
      logic [5:0] o;
      bit valid;
      int st;
      o = '0; valid = 0; st = 0;
      if (bk) return {1'b0, 6'b111000};
      if (q) begin
         valid = (sp == 0);
         for (int i = 0; i < 4; i++) if (quad_code[i] == (h >> 1)) st = i;
         if (!f) st = (st + 2) % 4;
         if (valid && ok) o[quad_out[st]] = 1'b1;
      end else begin
         for (int i = 0; i < 6; i++) if (seq[sp][i] == h) begin valid = 1; st = i; end
         if (!f) st = (st + 3) % 6;
         if (valid && ok) begin o[up_of[st]] = 1'b1; o[lo_of[st]] = 1'b1; end
      end
      return {!valid, o};
   endfunction

   task automatic check(string req, logic [6:0] got, logic [6:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b (hall=%b sp=%0d quad=%0b fwd=%0b brake=%0b ok=%0b)",
                  req, got, exp, hall, spacing, quad, fwd, brake, drive_ok);
      end
   endtask

   task automatic edges(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #100000;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      string tag;
      logic [6:0] e;
      hall = 3'b111;
      brake = 1'b1;
      edges(4);
      // R9: reset state on both polarities
      check("R9", {bad, sw}, 7'b0_000000);
      check("R9", {bad_inv, sw_inv}, 7'b0_000111);
      brake = 1'b0;
      rst_n = 1'b1;
      edges(4);

      for (int sp = 0; sp < 4; sp++)
       for (int q = 0; q < 2; q++)
        for (int f = 0; f < 2; f++)
         for (int bk = 0; bk < 2; bk++)
          for (int ok = 0; ok < 2; ok++)
           for (int h = 0; h < 8; h++) begin
              spacing = 2'(sp); quad = 1'(q); fwd = 1'(f);
              brake = 1'(bk); drive_ok = 1'(ok); hall = 3'(h);
              edges(4);
              e = model(h, sp, 1'(q), 1'(f), 1'(bk), 1'(ok));
              if (bk)             tag = "R6";
              else if (!ok)       tag = "R7";
              else if (q)         tag = (sp != 0) ? "R5" : "R4";
              else if (e[6])      tag = "R3";
              else                tag = f ? "R1" : "R2";
              check(tag, {bad, sw}, e);
              check("R8", {bad_inv, sw_inv}, e ^ 7'b0_000111);
              // R11: no leg with both switches on
              check("R11", {4'b0, sw[2:0] & sw[5:3]}, 7'b0);
           end

      // R10: sensor path latency of three edges, control path of one
      spacing = 2'd0; quad = 1'b0; fwd = 1'b1; brake = 1'b0; drive_ok = 1'b1;
      hall = 3'b000;
      edges(4);
      hall = 3'b100;
      edges(2);
      check("R10", {bad, sw}, 7'b0_010001);
      edges(1);
      check("R10", {bad, sw}, 7'b0_010100);
      brake = 1'b1;
      edges(1);
      check("R10", {bad, sw}, 7'b0_111000);
      brake = 1'b0;
      drive_ok = 1'b0;
      edges(1);
      check("R10", {bad, sw}, 7'b0_000000);

      finish_run();
   end

endmodule